// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector with Filtered Lock Flag

This block compares two slow square waves, a divided reference and a divided feedback, by sampling them on a fast system clock. When a rising edge of the reference comes first, it holds an active-low "raise frequency" pump output low until the matching feedback edge arrives. When the feedback edge comes first, it does the same on an active-low "lower frequency" output. The time an output spends low grows with the phase error, in whole system-clock cycles. When both edges have been seen, both outputs are low together for exactly one cycle and then both are released.

A raw activity signal is high whenever either pump output is low. A saturating quiet-cycle counter stands in for an external RC smoothing network. It clears on any pump activity and counts each cycle without activity. The lock flag is raised once the number of quiet cycles reaches a programmable length. Both inputs are assumed to be synchronous to the system clock already. Reset is synchronous and active high.

Top module: `pfd_lock`

## Requirements
- R1: While `rst` is high, `up_n` and `dn_n` are 1 and `locked` is 0. An input level that is already high when reset is released does not count as a rising edge.
- R2: Falling edges and steady levels on `ref_in` or `fb_in` produce no pump pulse.
- R3: When `ref_in` rises d cycles before `fb_in` (d >= 1), `up_n` is low for d+1 consecutive cycles, starting the cycle after the reference edge is sampled. `dn_n` is low only in the last of those cycles.
- R4: When `fb_in` rises d cycles before `ref_in` (d >= 1), `dn_n` is low for d+1 cycles and `up_n` is low only in the last of them.
- R5: When both inputs rise in the same cycle, both pump outputs are low for exactly one cycle.
- R6: Further rising edges of the leading input before the lagging edge arrives neither restart nor extend the pulse. The width is measured from the first leading edge.
- R7: `up_n` and `dn_n` are never both low in two consecutive cycles.
- R8: `pump_any` is 1 exactly when `up_n` or `dn_n` is 0.
- R9: `locked` is 0 in every cycle in which `up_n` or `dn_n` is 0.
- R10: Number the quiet cycles after pump activity ends from 0. `locked` first reads 1 in quiet cycle number `lock_len`. With `lock_len` = 0, `locked` is the plain AND of the two pump outputs.
- R11: The quiet counter saturates at 2^CNT_W-1. With `lock_len` at that maximum, lock is reached and then held for as long as there is no activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Divided reference square wave |
| fb_in | input | 1 | Divided feedback square wave |
| lock_len | input | CNT_W | Quiet cycles required before lock |
| up_n | output | 1 | Raise-frequency pump, active low |
| dn_n | output | 1 | Lower-frequency pump, active low |
| pump_any | output | 1 | Raw activity, high when either pump is low |
| locked | output | 1 | Filtered lock flag |

## Verification
An edge flag that is stuck, or one that is not cleared, shows up within one cycle of the lagging edge: a pump width becomes wrong by one or more cycles, or both outputs stay low together. A lost or spurious edge memory appears as a pulse after a falling edge or after reset release. A wrong quiet count moves the first `locked` cycle away from quiet cycle `lock_len`. A wrapping counter drops lock one cycle after the count reaches its maximum.

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [CNT_W-1:0] lock_len,
  output logic             up_n,
  output logic             dn_n,
  output logic             pump_any,
  output logic             locked
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic ref_q, fb_q, up_f, dn_f;
  logic ref_rise, fb_rise;
  logic [CNT_W-1:0] quiet_cnt;

  assign ref_rise = ref_in & ~ref_q;
  assign fb_rise  = fb_in & ~fb_q;

  always_ff @(posedge clk) begin
    ref_q <= ref_in;
    fb_q  <= fb_in;
    if (rst) begin
      up_f <= 1'b0;
      dn_f <= 1'b0;
    end else if (up_f && dn_f) begin
      up_f <= 1'b0;
      dn_f <= 1'b0;
    end else begin
      up_f <= up_f | ref_rise;
      dn_f <= dn_f | fb_rise;
    end
  end

  assign up_n     = ~up_f;
  assign dn_n     = ~dn_f;
  assign pump_any = ~(up_n & dn_n);

  always_ff @(posedge clk) begin
    if (rst || pump_any)
      quiet_cnt <= '0;
    else if (quiet_cnt != CNT_MAX)
      quiet_cnt <= quiet_cnt + 1'b1;
  end

  assign locked = ~rst & ~pump_any & (quiet_cnt >= lock_len);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (up_n && dn_n));
  // R7
  shared_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!up_n && !dn_n) |=> (up_n && dn_n));
  // R3
  ref_first_chk: assert property (@(posedge clk) disable iff (rst)
    (up_n && dn_n && ref_rise && !fb_rise) |=> (!up_n && dn_n));
  // R4
  fb_first_chk: assert property (@(posedge clk) disable iff (rst)
    (up_n && dn_n && fb_rise && !ref_rise) |=> (up_n && !dn_n));
  // R10
  lock_after_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && lock_len != '0) |-> $past(up_n && dn_n));
  // R11
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet_cnt == CNT_MAX && !pump_any) |=> (quiet_cnt == CNT_MAX));
endmodule

// File: tb/sim_pfd_lock.sv
module sim_pfd_lock;
  localparam int CNT_W = 8;
  logic clk = 0, rst = 1, ref_in = 0, fb_in = 0;
  logic [CNT_W-1:0] lock_len = '0;
  logic up_n, dn_n, pump_any, locked;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pfd_lock #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .lock_len(lock_len),
    .up_n(up_n), .dn_n(dn_n), .pump_any(pump_any), .locked(locked));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int bad_r8 = 0, bad_r9 = 0, bad_r7 = 0;
  logic prev_both = 0;

  // samples at negedge; keeps continuous R7/R8/R9 tallies
  task automatic smp();
    @(negedge clk);
    if (!rst) begin
      if (pump_any !== (!up_n || !dn_n)) bad_r8++;
      if (locked && (!up_n || !dn_n)) bad_r9++;
      if (prev_both && !up_n && !dn_n) bad_r7++;
      prev_both = !up_n && !dn_n;
    end
  endtask

  // rises on ref at step dr, fb at step df; counts low cycles
  task automatic run_pair(string req, int dr, int df, int e_up, int e_dn, int e_both);
    int nu = 0, nd = 0, nb = 0;
    int last = (dr > df ? dr : df) + 6;
    for (int i = 0; i <= last; i++) begin
      smp();
      if (i > 0) begin
        if (!up_n) nu++;
        if (!dn_n) nd++;
        if (!up_n && !dn_n) nb++;
      end
      ref_in = (i >= dr);
      fb_in  = (i >= df);
    end
    chk(req, "up_n low cycles", nu, e_up);
    chk(req, "dn_n low cycles", nd, e_dn);
    chk(req, "both low cycles", nb, e_both);
    ref_in = 0; fb_in = 0;
    repeat (4) smp();
  endtask

  task automatic t_reset();
    rst = 1; ref_in = 1; fb_in = 1;
    repeat (3) smp();
    chk("R1", "up_n in reset", up_n, 1);
    chk("R1", "dn_n in reset", dn_n, 1);
    chk("R1", "locked in reset", locked, 0);
    rst = 0;
    begin
      int nlow = 0;
      for (int i = 0; i < 6; i++) begin smp(); if (!up_n || !dn_n) nlow++; end
      chk("R1", "pulses from level held through reset", nlow, 0);
      ref_in = 0; fb_in = 0;
      nlow = 0;
      for (int i = 0; i < 8; i++) begin smp(); if (!up_n || !dn_n) nlow++; end
      chk("R2", "pulses from falling edges", nlow, 0);
    end
  endtask

  task automatic t_freq_lead();
    int nu = 0, nd = 0;
    for (int i = 0; i <= 14; i++) begin
      smp();
      if (i > 0) begin if (!up_n) nu++; if (!dn_n) nd++; end
      ref_in = (i == 0 || i == 1 || i == 4 || i == 5);
      fb_in  = (i >= 8);
    end
    chk("R6", "up_n width with repeated ref edges", nu, 9);
    chk("R6", "dn_n width", nd, 1);
    ref_in = 0; fb_in = 0;
    repeat (4) smp();
  endtask

  task automatic t_lock(string req, int len, int hold);
    int q = 0, seen_low = 0, got = -1, drop = 0;
    lock_len = len[CNT_W-1:0];
    for (int i = 0; i < len + 20 && got < 0; i++) begin
      smp();
      if (!up_n || !dn_n) begin seen_low = 1; q = 0; end
      else if (seen_low) begin
        if (locked) got = q;
        q++;
      end
      ref_in = (i >= 1 && i < 3);
      fb_in  = (i >= 1 && i < 3);
    end
    chk(req, "quiet cycles before lock", got, len);
    for (int i = 0; i < hold; i++) begin smp(); if (!locked) drop++; end
    chk(req, "lock dropouts while quiet", drop, 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    run_pair("R3", 0, 3, 4, 1, 1);
    run_pair("R3", 2, 9, 8, 1, 1);
    run_pair("R4", 5, 1, 1, 5, 1);
    run_pair("R5", 2, 2, 1, 1, 1);
    t_freq_lead();
    t_lock("R10", 0, 5);
    t_lock("R10", 5, 5);
    t_lock("R11", 255, 30);
    ref_in = 1; fb_in = 0;
    smp(); smp();
    chk("R9", "locked with up_n low", locked, 0);
    fb_in = 1;
    repeat (4) smp();
    chk("R8", "raw activity mismatches", bad_r8, 0);
    chk("R9", "lock during pump activity", bad_r9, 0);
    chk("R7", "consecutive both-low cycles", bad_r7, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule